// File: doc/BRIEF.md
# Memory Self-Test Failure Logger

This block sits beside a memory self-test controller and captures one diagnostic record for every compare mismatch the controller reports. A record holds three fields: the failing address, the index of the test step that was running, and a difference mask (expected data XOR read data). Records enter a small dual-clock queue in the fast test clock domain. A serial unloader in the slow tester clock domain reads them out one bit at a time.

When the queue fills up faster than the tester can drain it, the logger raises a halt request and the controller stops. The logger keeps a count of the failures it has already logged, and that count is the resume point. The tester waits for the queue to drain and then restarts the whole test from the beginning. On the rerun the logger drops the first mismatches, as many as the resume point, so the controller again runs at full speed through every cell while no record is logged twice. When a pass finishes without a halt and the queue has drained to the tester, the logger raises a final-complete flag.

Test-domain control FSM states:
- `C_IDLE`: after reset. Moves to `C_RUN` on `run_start`.
- `C_RUN`: capturing. Moves to `C_HALT` when the queue fill reaches the threshold, otherwise to `C_DONE` on `test_done`.
- `C_HALT`: halt requested. Moves to `C_RUN` on `run_start`.
- `C_DONE`: pass complete. Moves to `C_RUN` on `run_start`.

Unloader FSM states:
- `U_IDLE`: moves to `U_SHIFT` when the queue is non-empty, popping one record.
- `U_SHIFT`: returns to `U_IDLE` after the last bit.

Top module: `bist_fail_logger`

## Requirements
- R1: Each record is `{mis_addr, mis_step, mis_exp ^ mis_rd}`, AW+SW+DW bits wide. It is sent on `ser_out` most significant bit first, one bit per `uclk` cycle while `ser_valid` is high, with `ser_last` high on the final bit only.
- R2: Across any sequence of halts and reruns, every distinct failure reaches the serial output exactly once, in the order the controller first reports it.
- R3: When the queue fill seen by the test domain is at least DEPTH-HALT_MARGIN during `C_RUN`, `halt_req` rises on the next `tclk` edge. It stays high until `run_start`.
- R4: `run_start` begins a pass. The first `reported_cnt` mismatches of that pass are discarded, and `reported_cnt` ends equal to the number of distinct failures.
- R5: A mismatch that arrives while the queue is full is not logged and not counted. Mismatches later in the same pass are not logged either, so the capture order has no gaps.
- R6: `all_reported` is high only in `C_DONE` with the queue fully drained. It is low whenever a halt is pending.
- R7: `buf_empty` is high only when no record is queued and none is being shifted.
- R8: After reset, `halt_req`, `all_reported` and `ser_valid` are low, `buf_empty` is high and `reported_cnt` is zero.
- R9: `ser_valid` stays high for exactly AW+SW+DW consecutive cycles per record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk | input | 1 | Test clock (fast) |
| trst_n | input | 1 | Test-domain reset, active low |
| run_start | input | 1 | Start or restart a test pass |
| test_done | input | 1 | Controller finished a pass |
| mis_valid | input | 1 | Compare mismatch this cycle |
| mis_addr | input | AW | Failing address |
| mis_step | input | SW | Test step index |
| mis_exp | input | DW | Expected data |
| mis_rd | input | DW | Read data |
| halt_req | output | 1 | Stop request to the controller |
| all_reported | output | 1 | Pass completed and every record drained |
| reported_cnt | output | CW | Failures logged so far (resume point) |
| uclk | input | 1 | Tester clock (slow) |
| urst_n | input | 1 | Tester-domain reset, active low |
| ser_out | output | 1 | Serial record data, MSB first |
| ser_valid | output | 1 | Serial bit valid |
| ser_last | output | 1 | Last bit of a record |
| buf_empty | output | 1 | Nothing queued or shifting |

## Verification
A wrong skip count or resume point shows up at the serial port as a duplicated or missing record. The scoreboard catches this at the first record unloaded after the affected rerun. A wrong halt threshold or a full-queue write shows up as a lost record, which appears as an out-of-order compare within one record time, or as a final `reported_cnt` that differs from the failure total. A fault in the unloader FSM breaks the bit count or the `ser_last` position of the very next record.

// File: rtl/blog_pkg.sv
package blog_pkg;
    typedef enum logic [1:0] {
        C_IDLE = 2'd0,
        C_RUN  = 2'd1,
        C_HALT = 2'd2,
        C_DONE = 2'd3
    } ctrl_st_t;

    typedef enum logic {
        U_IDLE  = 1'b0,
        U_SHIFT = 1'b1
    } unl_st_t;
endpackage

// File: rtl/blog_sync.sv
module blog_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/blog_afifo.sv
module blog_afifo #(
    parameter int W     = 20,
    parameter int DEPTH = 8
) (
    input  logic          wclk,
    input  logic          wrst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wdata,
    output logic          full,
    output logic [$clog2(DEPTH):0] fill,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          rd_en,
    output logic [W-1:0]  rdata,
    output logic          empty
);
    localparam int AI = $clog2(DEPTH);
    localparam int PW = AI + 1;

    function automatic logic [PW-1:0] to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] rgray_w, wgray_r;
    logic [PW-1:0] wbin_nx, rbin_nx;

    assign wbin_nx = wbin + PW'(1);
    assign rbin_nx = rbin + PW'(1);

    always_ff @(posedge wclk or negedge wrst_n) begin
        if (!wrst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wr_en) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_en) mem[wbin[AI-1:0]] <= wdata;
    end

    always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rd_en) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    blog_sync #(.W(PW), .STAGES(2)) u_r2w (
        .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
    );
    blog_sync #(.W(PW), .STAGES(2)) u_w2r (
        .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
    );

    assign fill  = wbin - to_bin(rgray_w);
    assign full  = (fill == PW'(DEPTH));
    assign empty = (rgray == wgray_r);
    assign rdata = mem[rbin[AI-1:0]];

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
        wr_en |-> !full); // R5
    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
        rd_en |-> !empty); // R7
    AST_FILL_BOUND: assert property (@(posedge wclk) disable iff (!wrst_n)
        fill <= PW'(DEPTH)); // R5
endmodule

// File: rtl/blog_ctrl.sv
module blog_ctrl
    import blog_pkg::*;
#(
    parameter int RW          = 20,
    parameter int DEPTH       = 8,
    parameter int HALT_MARGIN = 2,
    parameter int CW          = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_start,
    input  logic          test_done,
    input  logic          mis_valid,
    input  logic [RW-1:0] rec_in,
    input  logic          fifo_full,
    input  logic [$clog2(DEPTH):0] fifo_fill,
    output logic          wr_en,
    output logic [RW-1:0] wr_data,
    output logic          halt_req,
    output logic          all_reported,
    output logic [CW-1:0] reported_cnt
);
    localparam int PW  = $clog2(DEPTH) + 1;
    localparam int THR = DEPTH - HALT_MARGIN;

    ctrl_st_t st, st_nx;
    logic [CW-1:0] seen_cnt;
    logic          active, accept, at_front, restart, over_thr;

    assign active   = (st == C_RUN) || (st == C_HALT);
    assign accept   = active && mis_valid;
    assign at_front = (seen_cnt == reported_cnt);
    assign restart  = run_start && (st != C_RUN);
    assign over_thr = (fifo_fill >= PW'(THR));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= C_IDLE;
        else        st <= st_nx;
    end

    // next state and outputs
    always_comb begin
        st_nx        = st;
        wr_en        = accept && at_front && !fifo_full;
        wr_data      = rec_in;
        halt_req     = (st == C_HALT);
        all_reported = (st == C_DONE) && (fifo_fill == '0);
        unique case (st)
            C_IDLE: if (run_start) st_nx = C_RUN;
            C_RUN: begin
                if (over_thr)       st_nx = C_HALT;
                else if (test_done) st_nx = C_DONE;
            end
            C_HALT: if (run_start) st_nx = C_RUN;
            C_DONE: if (run_start) st_nx = C_RUN;
            default: st_nx = C_IDLE;
        endcase
    end

    // progress counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_cnt     <= '0;
            reported_cnt <= '0;
        end else begin
            if (restart)     seen_cnt <= '0;
            else if (accept) seen_cnt <= seen_cnt + CW'(1);
            if (wr_en) reported_cnt <= reported_cnt + CW'(1);
        end
    end

    AST_HALT_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (st == C_RUN && over_thr) |=> halt_req); // R3
    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !run_start) |=> halt_req); // R3
    AST_DONE_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        all_reported |-> !halt_req); // R6
    AST_LOG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (reported_cnt == $past(reported_cnt) + CW'(1))); // R4
    AST_SEEN_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !restart && !at_front && !fifo_full) |-> !wr_en); // R5
endmodule

// File: rtl/blog_unload.sv
module blog_unload
    import blog_pkg::*;
#(
    parameter int RW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          empty,
    input  logic [RW-1:0] rdata,
    output logic          rd_en,
    output logic          ser_out,
    output logic          ser_valid,
    output logic          ser_last,
    output logic          buf_empty
);
    localparam int BW = $clog2(RW);

    unl_st_t       st, st_nx;
    logic [RW-1:0] shreg;
    logic [BW-1:0] bitcnt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= U_IDLE;
        else        st <= st_nx;
    end

    // next state and outputs
    always_comb begin
        st_nx     = st;
        rd_en     = 1'b0;
        ser_valid = (st == U_SHIFT);
        ser_last  = (st == U_SHIFT) && (bitcnt == '0);
        ser_out   = (st == U_SHIFT) && shreg[RW-1];
        buf_empty = empty && (st == U_IDLE);
        unique case (st)
            U_IDLE: begin
                if (!empty) begin
                    rd_en = 1'b1;
                    st_nx = U_SHIFT;
                end
            end
            U_SHIFT: if (bitcnt == '0) st_nx = U_IDLE;
            default: st_nx = U_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
        end else if (rd_en) begin
            shreg  <= rdata;
            bitcnt <= BW'(RW - 1);
        end else if (st == U_SHIFT) begin
            shreg  <= {shreg[RW-2:0], 1'b0};
            bitcnt <= bitcnt - BW'(1);
        end
    end

    AST_LAST_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ser_last |-> ser_valid); // R1
    AST_FRAME_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_last) |=> ser_valid); // R9
    AST_BUSY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> !buf_empty); // R7
endmodule

// File: rtl/bist_fail_logger.sv
module bist_fail_logger #(
    parameter int AW          = 8,
    parameter int SW          = 4,
    parameter int DW          = 8,
    parameter int DEPTH       = 8,
    parameter int HALT_MARGIN = 2,
    parameter int CW          = 16
) (
    input  logic          tclk,
    input  logic          trst_n,
    input  logic          run_start,
    input  logic          test_done,
    input  logic          mis_valid,
    input  logic [AW-1:0] mis_addr,
    input  logic [SW-1:0] mis_step,
    input  logic [DW-1:0] mis_exp,
    input  logic [DW-1:0] mis_rd,
    output logic          halt_req,
    output logic          all_reported,
    output logic [CW-1:0] reported_cnt,
    input  logic          uclk,
    input  logic          urst_n,
    output logic          ser_out,
    output logic          ser_valid,
    output logic          ser_last,
    output logic          buf_empty
);
    localparam int RW = AW + SW + DW;
    localparam int PW = $clog2(DEPTH) + 1;

    logic [RW-1:0] rec_in, wr_data, rdata;
    logic          wr_en, fifo_full, rd_en, fifo_empty;
    logic [PW-1:0] fifo_fill;

    assign rec_in = {mis_addr, mis_step, mis_exp ^ mis_rd};

    blog_ctrl #(
        .RW(RW), .DEPTH(DEPTH), .HALT_MARGIN(HALT_MARGIN), .CW(CW)
    ) u_ctrl (
        .clk(tclk), .rst_n(trst_n),
        .run_start(run_start), .test_done(test_done),
        .mis_valid(mis_valid), .rec_in(rec_in),
        .fifo_full(fifo_full), .fifo_fill(fifo_fill),
        .wr_en(wr_en), .wr_data(wr_data),
        .halt_req(halt_req), .all_reported(all_reported),
        .reported_cnt(reported_cnt)
    );

    blog_afifo #(.W(RW), .DEPTH(DEPTH)) u_fifo (
        .wclk(tclk), .wrst_n(trst_n), .wr_en(wr_en), .wdata(wr_data),
        .full(fifo_full), .fill(fifo_fill),
        .rclk(uclk), .rrst_n(urst_n), .rd_en(rd_en), .rdata(rdata),
        .empty(fifo_empty)
    );

    blog_unload #(.RW(RW)) u_unload (
        .clk(uclk), .rst_n(urst_n), .empty(fifo_empty), .rdata(rdata),
        .rd_en(rd_en), .ser_out(ser_out), .ser_valid(ser_valid),
        .ser_last(ser_last), .buf_empty(buf_empty)
    );
endmodule

// File: tb/bist_fail_logger_tb_top.sv
`timescale 1ns/1ps
module bist_fail_logger_tb_top;
    localparam int AW = 8, SW = 4, DW = 8, DEPTH = 8, HM = 2, CW = 16;
    localparam int RW = AW + SW + DW;

    logic tclk = 0, uclk = 0, trst_n = 0, urst_n = 0;
    logic run_start = 0, test_done = 0, mis_valid = 0;
    logic [AW-1:0] mis_addr = '0;
    logic [SW-1:0] mis_step = '0;
    logic [DW-1:0] mis_exp = '0, mis_rd = '0;
    logic halt_req, all_reported, ser_out, ser_valid, ser_last, buf_empty;
    logic [CW-1:0] reported_cnt;

    always #5 tclk = ~tclk;
    always #23 uclk = ~uclk;

    bist_fail_logger #(.AW(AW), .SW(SW), .DW(DW), .DEPTH(DEPTH),
                       .HALT_MARGIN(HM), .CW(CW)) dut_i (.*);

    int checks = 0, fails = 0, pushed = 0, cyc = 0;
    bit done_flag = 0;
    logic [RW-1:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic bit fails_at(input int pat, input int c);
        if (pat == 1) return (c % 3) == 1;
        if (pat == 2) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [DW-1:0] mask_of(input int c);
        logic [DW-1:0] m;
        m = DW'(c * 29 + 3);
        return m | DW'(1);
    endfunction

    // monitor: assemble serial records and compare with the scoreboard
    int nbits = 0;
    logic [RW-1:0] acc = '0;
    always @(negedge uclk) begin
        if (urst_n && ser_valid) begin
            chk(!buf_empty, "R7 busy", buf_empty, 0);
            acc = {acc[RW-2:0], ser_out};
            nbits++;
            if (ser_last) begin
                chk(nbits == RW, "R9 frame length", nbits, RW);
                if (exp_q.size() == 0) chk(0, "R2 extra record", acc, 0);
                else begin
                    logic [RW-1:0] e;
                    e = exp_q.pop_front();
                    chk(acc == e, "R1 R2 record", acc, e);
                end
                nbits = 0;
            end
        end
    end

    task automatic do_reset();
        trst_n = 0; urst_n = 0;
        exp_q.delete(); pushed = 0; nbits = 0;
        repeat (4) @(negedge uclk);
        trst_n = 1; urst_n = 1;
        repeat (3) @(negedge tclk);
    endtask

    task automatic drain();
        repeat (4) @(negedge uclk);
        for (int r = 0; r < 2; r++) begin
            while (!buf_empty) @(negedge uclk);
            repeat (4) @(negedge uclk);
        end
        repeat (6) @(negedge tclk);
    endtask

    // driver: controller model, pushes newly seen failures to scoreboard
    task automatic run_pass(input int pat, input int ncell, input int lat, output bit halted);
        int k = 0, after = -1;
        halted = 0;
        @(negedge tclk) run_start = 1;
        @(negedge tclk) run_start = 0;
        for (int c = 0; c < ncell; c++) begin
            if (halt_req && after < 0) after = lat;
            if (after == 0) begin halted = 1; break; end
            if (after > 0) after--;
            if (fails_at(pat, c)) begin
                mis_valid = 1;
                mis_addr  = AW'(c);
                mis_step  = SW'(c % 5);
                mis_exp   = DW'(c * 7);
                mis_rd    = DW'(c * 7) ^ mask_of(c);
                if (k >= pushed) begin
                    exp_q.push_back({AW'(c), SW'(c % 5), mask_of(c)});
                    pushed++;
                end
                k++;
            end else mis_valid = 0;
            @(negedge tclk);
        end
        mis_valid = 0;
        if (!halted) begin
            test_done = 1;
            @(negedge tclk) test_done = 0;
            @(negedge tclk);
            halted = halt_req;
        end
    endtask

    task automatic full_test(input int pat, input int ncell, input int lat,
                             input int total, input bit expect_halt);
        bit h;
        int halts = 0, it = 0;
        do begin
            run_pass(pat, ncell, lat, h);
            if (h) begin
                halts++;
                chk(halt_req == 1, "R3 halt held", halt_req, 1);
                chk(all_reported == 0, "R6 not complete while halted", all_reported, 0);
                if (halts == 1 && lat > 0)
                    chk(reported_cnt <= CW'(DEPTH) && reported_cnt >= CW'(DEPTH - HM),
                        "R5 capture bounded by depth", reported_cnt, DEPTH);
                drain();
            end
            it++;
        end while (h && it < 60);
        drain();
        repeat (8) @(negedge tclk);
        chk(all_reported == 1, "R6 final complete", all_reported, 1);
        chk(reported_cnt == CW'(total), "R4 resume count", reported_cnt, total);
        chk(exp_q.size() == 0, "R2 all delivered", exp_q.size(), 0);
        chk((halts > 0) == expect_halt, "R3 halt occurrence", halts, expect_halt);
        repeat (10) @(negedge tclk);
        chk(all_reported == 1, "R6 held", all_reported, 1);
    endtask

    initial begin
        while (!done_flag) begin
            @(posedge tclk);
            cyc++;
            if (cyc > 150000) begin
                chk(0, "watchdog", cyc, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R8 reset state
        chk(halt_req == 0, "R8 halt_req", halt_req, 0);
        chk(all_reported == 0, "R8 all_reported", all_reported, 0);
        chk(ser_valid == 0, "R8 ser_valid", ser_valid, 0);
        chk(buf_empty == 1, "R8 buf_empty", buf_empty, 1);
        chk(reported_cnt == 0, "R8 reported_cnt", reported_cnt, 0);

        // clean memory: completes at once
        full_test(0, 30, 0, 0, 0);

        // sparse failures, fast controller reaction
        do_reset();
        full_test(1, 60, 0, 20, 1);

        // every cell fails, slow controller reaction forces full-queue drops
        do_reset();
        full_test(2, 24, 5, 24, 1);

        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule